// File: doc/BRIEF.md
# Entropy CRC Accumulator with Read Interlock

The block turns three free-running raw entropy bit streams into 64-bit random words. In each accumulation cycle, the bits of the enabled sources are XORed together. The result is shifted into a 64-bit CRC register, which software reads as a read-only data word. When the block runs in interlocked mode, a data read is held off with a stall until the programmed number of accumulation cycles has passed since the last successful read. This ensures that every word carries fresh entropy.

Software configures the block with four writes to the control address:

- The first three writes each carry an oscillator-select value. Write k stores that value for source k, and the block drives it out to the external oscillator of that source.
- The fourth write installs the final settings: the interlock mode bit, the source enables, the analog-select code and the wait count.
- After the fourth write the block is ready. Starting a new sequence drops readiness.

A second requester, a 32-bit consumer port, shares the data word. A fresh read returns the low half and keeps the high half in a one-word buffer. The next request is answered from that buffer.

Top module: `ent_accum_top`

## Requirements
- R1: After reset the CRC register is zero, `ready_o` is low, `osc_sel` is zero, and the wait count equals the `RST_WAIT` parameter. A data read returns status 1 (not ready) with data zero.
- R2: Control writes are counted in a sequence of four. Write k (k = 0, 1, 2) stores `wdata[7:6]` into oscillator field k, which drives `osc_sel[2k+1:2k]`, and forces `ready_o` low. The fourth write loads the mode from bit 0, the enables from bits 3:1, the analog select from bits 5:4 and the wait count from bits `8+WAIT_W-1:8`. It also raises `ready_o`.
- R3: On every clock edge where `ready_o` is high and at least one enable is set, the register does the following. It shifts left one bit. It XORs in 0x231DCEE91262B8A3 (the polynomial x^64+x^61+x^57+x^56+x^52+x^51+x^50+x^48+x^47+x^46+x^43+x^42+x^41+x^39+x^38+x^37+x^35+x^32+x^28+x^25+x^22+x^21+x^17+x^15+x^13+x^12+x^11+x^7+x^5+x+1 without its top term) when the old top bit XOR the input bit is 1. The input bit is the XOR of the enabled sources. When `ready_o` is low, the register does not change.
- R4: A source whose enable bit is clear has no influence on the accumulated value.
- R5: With the mode bit set, each successful data read and the fourth control write reload the interlock with the wait count W. Each accumulation cycle then counts the interlock down by one. A data read stalls while the count is non-zero. A data read issued at once therefore stalls for exactly W cycles.
- R6: With the mode bit clear, data reads never stall.
- R7: When the analog select equals 3 (muted), a data read is answered at once with status 2 (would block) and data zero. A bus read leaves `ready_o` unchanged. A bus response is valid one cycle after the request is accepted.
- R8: A control read never stalls. It returns status 0 with the mode at bit 0, the enables at bits 3:1, the analog select at bits 5:4, zero at bits 7:6, and the wait count at bit 8 upward.
- R9: A consumer request with the buffer empty performs a data read. It returns the low 32 bits with `cons_ok` high and keeps the high 32 bits. The next request is answered one cycle later from the buffer, without a register read and without reloading the interlock.
- R10: A consumer read that meets status 2 returns `cons_ok` low (zero bytes) and clears `ready_o`. Afterwards, reads report status 1 until a new four-write sequence completes.
- R11: A write to the data address has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_bits | input | 3 | Raw entropy bits, one per source |
| rd_req | input | 1 | Bus read request, held until not stalled |
| wr_req | input | 1 | Bus write strobe |
| addr | input | 1 | 0 = data word, 1 = control |
| wdata | input | 64 | Bus write data |
| stall | output | 1 | Current data read is held off |
| rd_valid | output | 1 | Bus read response valid |
| rdata | output | 64 | Bus read data |
| rd_status | output | 2 | 0 ok, 1 not ready, 2 would block |
| cons_req | input | 1 | Consumer request pulse |
| cons_valid | output | 1 | Consumer response valid |
| cons_ok | output | 1 | Response carries 4 bytes (low: zero bytes) |
| cons_data | output | 32 | Consumer data |
| ready_o | output | 1 | Block configured and usable |
| osc_sel | output | 6 | Per-source oscillator select, source 0 lowest |

## Verification
The bench builds the block with `WAIT_W` = 8 and `RST_WAIT` = 3. These values keep the interlock windows at a few cycles, so the exact stall count after each reload can be compared against the programmed count. The small wait field also makes the reset value of the wait count visible in a control read. The CRC is checked against an independent bit-serial model in several configurations:

- all sources enabled;
- a single source enabled;
- interlock off;
- a muted analog select;
- the consumer buffer path.

// File: rtl/ent_accum_pkg.sv
package ent_accum_pkg;

    localparam int CRC_W  = 64;
    localparam int SRC_N  = 3;
    localparam int OSC_W  = 2;
    localparam int ASEL_W = 2;

    localparam logic [CRC_W-1:0] CRC_POLY = 64'h231D_CEE9_1262_B8A3;

    // control word field positions (fourth write and control read)
    localparam int F_MODE = 0;
    localparam int F_EN   = 1;
    localparam int F_ASEL = 4;
    localparam int F_OSC  = 6;
    localparam int F_WAIT = 8;

    localparam logic [ASEL_W-1:0] ASEL_MUTE = 2'd3;

    typedef enum logic [1:0] {
        ST_OK     = 2'd0,
        ST_NOTRDY = 2'd1,
        ST_WBLK   = 2'd2
    } rd_status_e;

    typedef struct packed {
        logic [ASEL_W-1:0] asel;
        logic [SRC_N-1:0]  en;
        logic              mode;
    } mode_t;

    typedef enum logic {
        CS_IDLE = 1'b0,
        CS_PEND = 1'b1
    } cons_st_e;

endpackage

// File: rtl/ent_crc_core.sv
module ent_crc_core
    import ent_accum_pkg::*;
#(
    parameter int               W    = CRC_W,
    parameter logic [W-1:0]     POLY = CRC_POLY
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_en,
    input  logic [SRC_N-1:0] src,
    input  logic [SRC_N-1:0] en,
    output logic [W-1:0]     crc_q
);

    logic [SRC_N-1:0] gated;
    logic             mix;
    logic             fb;
    logic [W-1:0]     crc_nxt;

    for (genvar g = 0; g < SRC_N; g++) begin : g_gate
        assign gated[g] = src[g] & en[g];
    end

    assign mix = ^gated;
    assign fb  = crc_q[W-1] ^ mix;

    always_comb begin
        crc_nxt = {crc_q[W-2:0], 1'b0};
        if (fb) begin
            crc_nxt = crc_nxt ^ POLY;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= '0;
        end else if (acc_en) begin
            crc_q <= crc_nxt;
        end
    end

endmodule

// File: rtl/ent_ctl_seq.sv
module ent_ctl_seq
    import ent_accum_pkg::*;
#(
    parameter int WAIT_W   = 16,
    parameter int RST_WAIT = 64
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_stb,
    input  logic [CRC_W-1:0]       wdata,
    input  logic                   clr_ready,
    output mode_t                  cfg,
    output logic [WAIT_W-1:0]      wait_q,
    output logic [SRC_N*OSC_W-1:0] osc_sel,
    output logic                   ready,
    output logic                   final_wr
);

    localparam int SEQ_W = $clog2(SRC_N + 1);

    logic [SEQ_W-1:0] seq_q;
    logic [OSC_W-1:0] osc_q [SRC_N];
    logic             unused_wbits;

    assign unused_wbits = ^wdata;
    assign final_wr     = wr_stb && (seq_q == SEQ_W'(SRC_N));

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q  <= '0;
            cfg    <= '0;
            wait_q <= WAIT_W'(RST_WAIT);
            ready  <= 1'b0;
        end else if (final_wr) begin
            cfg.mode <= wdata[F_MODE];
            cfg.en   <= wdata[F_EN +: SRC_N];
            cfg.asel <= wdata[F_ASEL +: ASEL_W];
            wait_q   <= wdata[F_WAIT +: WAIT_W];
            ready    <= 1'b1;
            seq_q    <= '0;
        end else if (wr_stb) begin
            ready <= 1'b0;
            seq_q <= seq_q + SEQ_W'(1);
        end else if (clr_ready) begin
            ready <= 1'b0;
        end
    end

    for (genvar g = 0; g < SRC_N; g++) begin : g_osc
        always_ff @(posedge clk) begin
            if (rst) begin
                osc_q[g] <= '0;
            end else if (wr_stb && !final_wr && seq_q == SEQ_W'(g)) begin
                osc_q[g] <= wdata[F_OSC +: OSC_W];
            end
        end
        assign osc_sel[g*OSC_W +: OSC_W] = osc_q[g];
    end

endmodule

// File: rtl/ent_interlock.sv
module ent_interlock #(
    parameter int WAIT_W   = 16,
    parameter int RST_WAIT = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              tick,
    output logic              open
);

    logic [WAIT_W-1:0] cnt_q;

    assign open = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= WAIT_W'(RST_WAIT);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && !open) begin
            cnt_q <= cnt_q - WAIT_W'(1);
        end
    end

endmodule

// File: rtl/ent_consumer.sv
module ent_consumer
    import ent_accum_pkg::*;
#(
    parameter int W = CRC_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req,
    input  logic           gnt,
    input  rd_status_e     status,
    input  logic [W-1:0]   word,
    output logic           pend,
    output logic           err,
    output logic           valid,
    output logic           ok,
    output logic [W/2-1:0] data
);

    localparam int HALF_W = W / 2;

    cons_st_e          st_q;
    logic [HALF_W-1:0] buf_q;
    logic              buf_v;

    assign pend = (st_q == CS_PEND);
    assign err  = pend && gnt && (status == ST_WBLK);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= CS_IDLE;
            buf_q <= '0;
            buf_v <= 1'b0;
            valid <= 1'b0;
            ok    <= 1'b0;
            data  <= '0;
        end else begin
            valid <= 1'b0;
            unique case (st_q)
                CS_IDLE: begin
                    if (req && buf_v) begin
                        valid <= 1'b1;
                        ok    <= 1'b1;
                        data  <= buf_q;
                        buf_v <= 1'b0;
                    end else if (req) begin
                        st_q <= CS_PEND;
                    end
                end
                CS_PEND: begin
                    if (gnt) begin
                        valid <= 1'b1;
                        st_q  <= CS_IDLE;
                        if (status == ST_OK) begin
                            ok    <= 1'b1;
                            data  <= word[HALF_W-1:0];
                            buf_q <= word[W-1:HALF_W];
                            buf_v <= 1'b1;
                        end else begin
                            ok   <= 1'b0;
                            data <= '0;
                        end
                    end
                end
                default: st_q <= CS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ent_accum_top.sv
module ent_accum_top
    import ent_accum_pkg::*;
#(
    parameter int               WAIT_W   = 16,
    parameter int               RST_WAIT = 64,
    parameter logic [CRC_W-1:0] POLY     = CRC_POLY
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SRC_N-1:0]       src_bits,
    input  logic                   rd_req,
    input  logic                   wr_req,
    input  logic                   addr,
    input  logic [CRC_W-1:0]       wdata,
    output logic                   stall,
    output logic                   rd_valid,
    output logic [CRC_W-1:0]       rdata,
    output logic [1:0]             rd_status,
    input  logic                   cons_req,
    output logic                   cons_valid,
    output logic                   cons_ok,
    output logic [CRC_W/2-1:0]     cons_data,
    output logic                   ready_o,
    output logic [SRC_N*OSC_W-1:0] osc_sel
);

    mode_t             cfg;
    logic [WAIT_W-1:0] wait_q;
    logic              ready;
    logic              final_wr;
    logic              lock_open;
    logic [CRC_W-1:0]  crc_q;
    logic [CRC_W-1:0]  ctl_word;
    logic              acc_en;
    logic              wr_stb;
    logic              data_rd;
    logic              can_serve;
    logic              bus_gnt;
    logic              cons_pend;
    logic              cons_gnt;
    logic              cons_err;
    logic              ok_rd;
    logic              lock_load;
    logic [WAIT_W-1:0] lock_val;
    rd_status_e        cur_st;

    assign ready_o = ready;
    assign wr_stb  = wr_req & addr;
    assign acc_en  = ready & (|cfg.en);
    assign data_rd = rd_req & ~addr;

    always_comb begin
        if (!ready) begin
            cur_st = ST_NOTRDY;
        end else if (cfg.asel == ASEL_MUTE) begin
            cur_st = ST_WBLK;
        end else begin
            cur_st = ST_OK;
        end
    end

    assign can_serve = (cur_st != ST_OK) | ~cfg.mode | lock_open;
    assign stall     = data_rd & ~can_serve;
    assign bus_gnt   = rd_req & ~stall;
    assign cons_gnt  = cons_pend & ~rd_req & can_serve;
    assign ok_rd     = (cur_st == ST_OK) & ((data_rd & can_serve) | cons_gnt);
    assign lock_load = final_wr | ok_rd;
    assign lock_val  = final_wr ? wdata[F_WAIT +: WAIT_W] : wait_q;

    always_comb begin
        ctl_word                  = '0;
        ctl_word[F_MODE]          = cfg.mode;
        ctl_word[F_EN +: SRC_N]   = cfg.en;
        ctl_word[F_ASEL +: ASEL_W] = cfg.asel;
        ctl_word[F_WAIT +: WAIT_W] = wait_q;
    end

    ent_ctl_seq #(
        .WAIT_W   (WAIT_W),
        .RST_WAIT (RST_WAIT)
    ) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .wr_stb    (wr_stb),
        .wdata     (wdata),
        .clr_ready (cons_err),
        .cfg       (cfg),
        .wait_q    (wait_q),
        .osc_sel   (osc_sel),
        .ready     (ready),
        .final_wr  (final_wr)
    );

    ent_crc_core #(
        .W    (CRC_W),
        .POLY (POLY)
    ) u_crc (
        .clk    (clk),
        .rst    (rst),
        .acc_en (acc_en),
        .src    (src_bits),
        .en     (cfg.en),
        .crc_q  (crc_q)
    );

    ent_interlock #(
        .WAIT_W   (WAIT_W),
        .RST_WAIT (RST_WAIT)
    ) u_lock (
        .clk      (clk),
        .rst      (rst),
        .load     (lock_load),
        .load_val (lock_val),
        .tick     (acc_en),
        .open     (lock_open)
    );

    ent_consumer #(
        .W (CRC_W)
    ) u_cons (
        .clk    (clk),
        .rst    (rst),
        .req    (cons_req),
        .gnt    (cons_gnt),
        .status (cur_st),
        .word   (crc_q),
        .pend   (cons_pend),
        .err    (cons_err),
        .valid  (cons_valid),
        .ok     (cons_ok),
        .data   (cons_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid  <= 1'b0;
            rdata     <= '0;
            rd_status <= ST_OK;
        end else begin
            rd_valid <= bus_gnt;
            if (bus_gnt) begin
                if (addr) begin
                    rdata     <= ctl_word;
                    rd_status <= ST_OK;
                end else begin
                    rdata     <= (cur_st == ST_OK) ? crc_q : '0;
                    rd_status <= cur_st;
                end
            end
        end
    end

endmodule

// File: rtl/ent_accum_chk.sv
module ent_accum_chk
    import ent_accum_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             rd_req,
    input logic             wr_req,
    input logic             addr,
    input logic             stall,
    input logic             rd_valid,
    input logic [1:0]       rd_status,
    input logic [CRC_W-1:0] rdata,
    input logic             cons_valid,
    input logic             cons_ok,
    input logic             ready_o,
    input logic [CRC_W-1:0] crc_q
);

    p_ready_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> $past(wr_req && addr));

    p_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        !ready_o |=> $stable(crc_q));

    p_stall_data_r5: assert property (@(posedge clk) disable iff (rst)
        stall |-> (rd_req && !addr && ready_o));

    p_valid_grant_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_req && !stall));

    p_err_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_status != 2'd0) |-> (rdata == '0));

    p_cons_err_r10: assert property (@(posedge clk) disable iff (rst)
        (cons_valid && !cons_ok) |-> !ready_o);

    p_one_op_r11: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && wr_req));

endmodule

bind ent_accum_top ent_accum_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_req     (rd_req),
    .wr_req     (wr_req),
    .addr       (addr),
    .stall      (stall),
    .rd_valid   (rd_valid),
    .rd_status  (rd_status),
    .rdata      (rdata),
    .cons_valid (cons_valid),
    .cons_ok    (cons_ok),
    .ready_o    (ready_o),
    .crc_q      (crc_q)
);

// File: tb/sim_ent_accum_top.sv
module sim_ent_accum_top;

    localparam int CLK_PERIOD = 10;
    localparam int WW = 8;
    localparam int RW = 3;
    localparam logic [63:0] P = 64'h231D_CEE9_1262_B8A3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  src;
    logic        rd_req = 1'b0;
    logic        wr_req = 1'b0;
    logic        addr = 1'b0;
    logic [63:0] wdata = '0;
    logic        stall;
    logic        rd_valid;
    logic [63:0] rdata;
    logic [1:0]  rd_status;
    logic        cons_req = 1'b0;
    logic        cons_valid;
    logic        cons_ok;
    logic [31:0] cons_data;
    logic        ready_o;
    logic [5:0]  osc_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ent_accum_top #(.WAIT_W(WW), .RST_WAIT(RW)) u0 (
        .clk(clk), .rst(rst), .src_bits(src), .rd_req(rd_req), .wr_req(wr_req),
        .addr(addr), .wdata(wdata), .stall(stall), .rd_valid(rd_valid),
        .rdata(rdata), .rd_status(rd_status), .cons_req(cons_req),
        .cons_valid(cons_valid), .cons_ok(cons_ok), .cons_data(cons_data),
        .ready_o(ready_o), .osc_sel(osc_sel)
    );

    // entropy stimulus, changes only at falling edges
    logic [15:0] lf = 16'hACE1;
    always @(negedge clk) lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    assign src = lf[2:0];

    // bit-serial reference of the accumulator
    logic [63:0] m_crc = '0;
    logic [63:0] m_prev = '0;
    logic        m_acc = 1'b0;
    logic [2:0]  m_en = '0;

    function automatic logic [63:0] m_step(logic [63:0] c, logic b);
        logic fb;
        fb = c[63] ^ b;
        c = c << 1;
        if (fb) c = c ^ P;
        return c;
    endfunction

    always @(posedge clk) begin
        m_prev <= m_crc;
        if (rst) m_crc <= '0;
        else if (m_acc) m_crc <= m_step(m_crc, ^(src & m_en));
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic bus_write(input logic a, input logic [63:0] d);
        wr_req = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [63:0] d, output logic [1:0] st,
                            output int stalls);
        rd_req = 1'b1; addr = a;
        #1;
        stalls = 0;
        while (stall) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        rd_req = 1'b0;
        chk("R7 response valid", 64'(rd_valid), 64'd1);
        d = rdata;
        st = rd_status;
    endtask

    task automatic cons_read(output logic ok, output logic [31:0] d, output int lat);
        cons_req = 1'b1;
        @(negedge clk);
        cons_req = 1'b0;
        lat = 1;
        while (!cons_valid) begin
            @(negedge clk);
            lat++;
        end
        ok = cons_ok;
        d = cons_data;
    endtask

    function automatic logic [63:0] ctl_val(input logic mode, input logic [2:0] en,
                                            input logic [1:0] asel, input logic [7:0] wt);
        logic [63:0] w;
        w = '0;
        w[0] = mode; w[3:1] = en; w[5:4] = asel; w[15:8] = wt;
        return w;
    endfunction

    task automatic osc_writes();
        for (int k = 0; k < 3; k++) begin
            logic [63:0] w;
            w = '0;
            w[7:6] = 2'(k + 1);
            w[k + 1] = 1'b1;
            bus_write(1'b1, w);
            m_acc = 1'b0;
        end
    endtask

    task automatic configure(input logic mode, input logic [2:0] en,
                             input logic [1:0] asel, input logic [7:0] wt);
        osc_writes();
        bus_write(1'b1, ctl_val(mode, en, asel, wt));
        m_en = en;
        m_acc = (en != 3'b000);
    endtask

    task automatic t_reset();
        logic [63:0] d; logic [1:0] st; int s;
        chk("R1 ready low", 64'(ready_o), 64'd0);
        chk("R1 osc_sel zero", 64'(osc_sel), 64'd0);
        bus_read(1'b0, d, st, s);
        chk("R1 data status not ready", 64'(st), 64'd1);
        chk("R1 data zero", d, 64'd0);
        bus_read(1'b1, d, st, s);
        chk("R1 R8 control at reset", d, 64'(RW) << 8);
    endtask

    task automatic t_sequence();
        logic [63:0] d; logic [1:0] st; int s;
        osc_writes();
        chk("R2 ready low mid sequence", 64'(ready_o), 64'd0);
        chk("R2 osc fields", 64'(osc_sel), 64'b11_10_01);
        bus_write(1'b1, ctl_val(1'b1, 3'b111, 2'd2, 8'd5));
        m_en = 3'b111; m_acc = 1'b1;
        chk("R2 ready after fourth write", 64'(ready_o), 64'd1);
        bus_read(1'b0, d, st, s);
        chk("R5 stall count after config", 64'(s), 64'd5);
        chk("R3 status ok", 64'(st), 64'd0);
        chk("R3 crc word", d, m_prev);
        bus_read(1'b0, d, st, s);
        chk("R5 stall count after read", 64'(s), 64'd5);
        chk("R3 crc word second", d, m_prev);
        bus_read(1'b1, d, st, s);
        chk("R8 control readback", d, ctl_val(1'b1, 3'b111, 2'd2, 8'd5));
        chk("R8 control no stall", 64'(s), 64'd0);
    endtask

    task automatic t_ignore_write();
        logic [63:0] d; logic [1:0] st; int s;
        bus_write(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_read(1'b1, d, st, s);
        chk("R11 control unchanged", d, ctl_val(1'b1, 3'b111, 2'd2, 8'd5));
        chk("R11 ready kept", 64'(ready_o), 64'd1);
        bus_read(1'b0, d, st, s);
        chk("R11 crc unaffected", d, m_prev);
    endtask

    task automatic t_single_source();
        logic [63:0] d; logic [1:0] st; int s;
        configure(1'b1, 3'b001, 2'd1, 8'd3);
        for (int i = 0; i < 40; i++) @(negedge clk);
        bus_read(1'b0, d, st, s);
        chk("R4 one source crc", d, m_prev);
        chk("R4 no stall after window", 64'(s), 64'd0);
    endtask

    task automatic t_no_interlock();
        logic [63:0] d; logic [1:0] st; int s;
        configure(1'b0, 3'b110, 2'd2, 8'd7);
        bus_read(1'b0, d, st, s);
        chk("R6 no stall", 64'(s), 64'd0);
        chk("R6 crc", d, m_prev);
        bus_read(1'b0, d, st, s);
        chk("R6 no stall back to back", 64'(s), 64'd0);
    endtask

    task automatic t_consumer();
        logic ok; logic [31:0] d; int lat; logic [31:0] hi;
        configure(1'b1, 3'b111, 2'd2, 8'd4);
        cons_read(ok, d, lat);
        chk("R9 fresh ok", 64'(ok), 64'd1);
        chk("R9 low half", 64'(d), 64'(m_prev[31:0]));
        hi = m_prev[63:32];
        cons_read(ok, d, lat);
        chk("R9 buffered latency", 64'(lat), 64'd1);
        chk("R9 buffered high half", 64'(d), 64'(hi));
        cons_read(ok, d, lat);
        chk("R9 second fresh low", 64'(d), 64'(m_prev[31:0]));
        hi = m_prev[63:32];
        cons_read(ok, d, lat);
        chk("R9 second buffered high", 64'(d), 64'(hi));
    endtask

    task automatic t_mute();
        logic [63:0] d; logic [1:0] st; int s; logic ok; logic [31:0] cd; int lat;
        configure(1'b1, 3'b111, 2'd3, 8'd6);
        bus_read(1'b0, d, st, s);
        chk("R7 would block status", 64'(st), 64'd2);
        chk("R7 data zero", d, 64'd0);
        chk("R7 no stall", 64'(s), 64'd0);
        chk("R7 ready kept", 64'(ready_o), 64'd1);
        cons_read(ok, cd, lat);
        m_acc = 1'b0;
        chk("R10 zero bytes", 64'(ok), 64'd0);
        chk("R10 ready cleared", 64'(ready_o), 64'd0);
        bus_read(1'b0, d, st, s);
        chk("R10 not ready after error", 64'(st), 64'd1);
        configure(1'b1, 3'b111, 2'd2, 8'd2);
        bus_read(1'b0, d, st, s);
        chk("R10 ready again status", 64'(st), 64'd0);
        chk("R10 crc after recovery", d, m_prev);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_sequence();
        t_ignore_write();
        t_single_source();
        t_no_interlock();
        t_consumer();
        t_mute();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule